// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block decodes the host write cycles aimed at one NOR-style flash bank. On each write strobe it samples the address and data. It follows the multi-cycle unlock and command sequences, and when a sequence completes it launches the matching embedded operation. The launch is a single-cycle start pulse for program, chip erase or sector erase, with the target address and data held alongside it. The embedded algorithms, the array and the high-voltage control belong to other blocks. The only thing this block takes back from the algorithm engine is a busy level, which freezes command decoding.

The decoder has two modes. In read mode every command needs the full unlock preamble. In bypass mode, which is persistent, programs take two cycles and erases take four, and anything outside the short command set is dropped. The block leaves bypass mode only through a dedicated two-cycle exit. An acceleration input forces bypass mode for as long as it is held. The two mode flags let the surrounding bank logic steer array reads.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `read_mode` is 1, `bypass_mode` is 0 and no start pulse is active. The two mode flags are never 1 at the same time.
- R2: Read-mode program: the four writes AAh@555h, 55h@2AAh, A0h@555h, then (A, D) produce `prog_start` in the cycle after the fourth write, with `op_addr`=A and `op_data`=D. The decoder then returns to read mode.
- R3: Read-mode erase: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 10h@555h produces `chip_erase_start` with `op_addr`=0 and `op_data`=0. The same sequence ending in 30h at address S produces `sect_erase_start` with `op_addr`=S and `op_data`=0.
- R4: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode: `bypass_mode`=1 and `read_mode`=0 in the cycle after the third write.
- R5: In bypass mode, A0h at any address followed by (A, D) produces `prog_start` with A and D. The decoder stays in bypass mode, so the pair may be repeated.
- R6: In bypass mode, 80h (any address), AAh@555h, 55h@2AAh, then 10h@555h or 30h@S launches chip erase or sector erase respectively, and the decoder stays in bypass mode.
- R7: In bypass mode, a write that does not fit the bypass command set produces no pulse and leaves the decoder in bypass mode. This includes a full read-mode unlock.
- R8: In bypass mode, 90h followed by 00h (any addresses) returns the decoder to read mode. 90h followed by any other data leaves it in bypass mode.
- R9: In read mode, a write that breaks a sequence returns the decoder to its idle read state, so the writes that would have followed launch nothing. F0h is one such write.
- R10: Writes made while `busy` is 1 are ignored and the sequence state is held. A sequence interrupted this way completes once `busy` falls.
- R11: While `accel` is 1 the decoder is in bypass mode from the next cycle on, and the bypass exit is not taken. The cycle after `accel` falls, the decoder is in read mode.
- R12: At most one start pulse is active in any cycle. Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; commands use bits 7:0 |
| busy | input | 1 | Algorithm engine busy; blocks command writes |
| accel | input | 1 | Acceleration request; forces bypass mode |
| prog_start | output | 1 | One-cycle program launch |
| chip_erase_start | output | 1 | One-cycle chip erase launch |
| sect_erase_start | output | 1 | One-cycle sector erase launch |
| op_addr | output | AW | Target address of the launched operation |
| op_data | output | DW | Program data; zero for erase |
| bypass_mode | output | 1 | Decoder is in bypass mode |
| read_mode | output | 1 | Decoder is idle in read mode |

## Verification
On every cycle the assertions check the following: the mode flags are exclusive, launches are one-hot and single-cycle, nothing launches after a busy cycle, and the mode follows the acceleration input when it is held and when it is released. Only the bench scenarios can show the sequence behaviour itself. That covers which write orders launch which operation and with which address and data, that broken or foreign sequences are dropped in each mode, and that the bypass exit and the busy hold behave as required. A scoreboard matches every launch against the operation the scenario expects.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] CMD_KEY1   = 8'hAA;
   localparam logic [7:0] CMD_KEY2   = 8'h55;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_ESETUP = 8'h80;
   localparam logic [7:0] CMD_BYPASS = 8'h20;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
   localparam logic [7:0] CMD_SECT   = 8'h30;
   localparam logic [7:0] CMD_EXIT1  = 8'h90;
   localparam logic [7:0] CMD_EXIT2  = 8'h00;

   typedef enum logic [3:0] {
      ST_READ, ST_UL1, ST_UL2, ST_PROG, ST_SETUP, ST_EUL1, ST_EUL2,
      ST_BYP, ST_BPROG, ST_BSETUP, ST_BEUL1, ST_BEUL2, ST_BEXIT
   } seq_state_t;

   typedef enum logic [1:0] {
      LAUNCH_NONE, LAUNCH_PROG, LAUNCH_CHIP, LAUNCH_SECT
   } launch_t;

   typedef struct packed {
      logic at_a1;
      logic at_a2;
      logic d_key1;
      logic d_key2;
      logic d_prog;
      logic d_esetup;
      logic d_bypass;
      logic d_chip;
      logic d_sect;
      logic d_exit1;
      logic d_exit2;
   } wr_class_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
   import flash_cmd_pkg::*;
#(
   parameter int              AW          = 12,
   parameter int              DW          = 8,
   parameter int              UNLOCK_BITS = 11,
   parameter logic [AW-1:0]   ADDR_A1     = AW'('h555),
   parameter logic [AW-1:0]   ADDR_A2     = AW'('h2AA)
) (
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output wr_class_t     cls
);
   localparam int CW = (UNLOCK_BITS >= AW) ? AW : UNLOCK_BITS;

   logic       hit_a1;
   logic       hit_a2;
   logic [7:0] cmd;

   assign cmd = data[7:0];

   generate
      if (CW == AW) begin : g_full_cmp
         assign hit_a1 = (addr == ADDR_A1);
         assign hit_a2 = (addr == ADDR_A2);
      end else begin : g_low_cmp
         assign hit_a1 = (addr[CW-1:0] == ADDR_A1[CW-1:0]);
         assign hit_a2 = (addr[CW-1:0] == ADDR_A2[CW-1:0]);
      end
   endgenerate

   always_comb begin
      cls.at_a1    = hit_a1;
      cls.at_a2    = hit_a2;
      cls.d_key1   = (cmd == CMD_KEY1);
      cls.d_key2   = (cmd == CMD_KEY2);
      cls.d_prog   = (cmd == CMD_PROG);
      cls.d_esetup = (cmd == CMD_ESETUP);
      cls.d_bypass = (cmd == CMD_BYPASS);
      cls.d_chip   = (cmd == CMD_CHIP);
      cls.d_sect   = (cmd == CMD_SECT);
      cls.d_exit1  = (cmd == CMD_EXIT1);
      cls.d_exit2  = (cmd == CMD_EXIT2);
   end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      busy,
   input  logic      accel,
   input  wr_class_t cls,
   output launch_t   launch,
   output logic      bypass_mode,
   output logic      read_mode
);
   seq_state_t state_q, state_d;
   logic       accel_q;
   logic       wr_ok;
   logic       in_byp;

   assign wr_ok  = wr_en && !busy;
   assign in_byp = state_q inside {ST_BYP, ST_BPROG, ST_BSETUP, ST_BEUL1,
                                   ST_BEUL2, ST_BEXIT};

   always_comb begin
      state_d = state_q;
      launch  = LAUNCH_NONE;
      if (accel_q && !accel) begin
         state_d = ST_READ;
      end else if (accel && !in_byp) begin
         state_d = ST_BYP;
      end else if (wr_ok) begin
         unique case (state_q)
            ST_READ:  state_d = (cls.at_a1 && cls.d_key1) ? ST_UL1 : ST_READ;
            ST_UL1:   state_d = (cls.at_a2 && cls.d_key2) ? ST_UL2 : ST_READ;
            ST_UL2: begin
               if (cls.at_a1 && cls.d_prog)        state_d = ST_PROG;
               else if (cls.at_a1 && cls.d_esetup) state_d = ST_SETUP;
               else if (cls.at_a1 && cls.d_bypass) state_d = ST_BYP;
               else                                state_d = ST_READ;
            end
            ST_PROG: begin
               launch  = LAUNCH_PROG;
               state_d = ST_READ;
            end
            ST_SETUP: state_d = (cls.at_a1 && cls.d_key1) ? ST_EUL1 : ST_READ;
            ST_EUL1:  state_d = (cls.at_a2 && cls.d_key2) ? ST_EUL2 : ST_READ;
            ST_EUL2: begin
               if (cls.at_a1 && cls.d_chip) launch = LAUNCH_CHIP;
               else if (cls.d_sect)         launch = LAUNCH_SECT;
               state_d = ST_READ;
            end
            ST_BYP: begin
               if (cls.d_prog)        state_d = ST_BPROG;
               else if (cls.d_esetup) state_d = ST_BSETUP;
               else if (cls.d_exit1)  state_d = ST_BEXIT;
            end
            ST_BPROG: begin
               launch  = LAUNCH_PROG;
               state_d = ST_BYP;
            end
            ST_BSETUP: state_d = (cls.at_a1 && cls.d_key1) ? ST_BEUL1 : ST_BYP;
            ST_BEUL1:  state_d = (cls.at_a2 && cls.d_key2) ? ST_BEUL2 : ST_BYP;
            ST_BEUL2: begin
               if (cls.at_a1 && cls.d_chip) launch = LAUNCH_CHIP;
               else if (cls.d_sect)         launch = LAUNCH_SECT;
               state_d = ST_BYP;
            end
            ST_BEXIT: state_d = (cls.d_exit2 && !accel) ? ST_READ : ST_BYP;
            default:  state_d = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_READ;
         accel_q <= 1'b0;
      end else begin
         state_q <= state_d;
         accel_q <= accel;
      end
   end

   assign bypass_mode = in_byp;
   assign read_mode   = (state_q == ST_READ);
endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
   import flash_cmd_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  launch_t       launch,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          prog_start,
   output logic          chip_erase_start,
   output logic          sect_erase_start,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_start       <= 1'b0;
         chip_erase_start <= 1'b0;
         sect_erase_start <= 1'b0;
         op_addr          <= '0;
         op_data          <= '0;
      end else begin
         prog_start       <= (launch == LAUNCH_PROG);
         chip_erase_start <= (launch == LAUNCH_CHIP);
         sect_erase_start <= (launch == LAUNCH_SECT);
         unique case (launch)
            LAUNCH_PROG: begin
               op_addr <= addr;
               op_data <= data;
            end
            LAUNCH_CHIP: begin
               op_addr <= '0;
               op_data <= '0;
            end
            LAUNCH_SECT: begin
               op_addr <= addr;
               op_data <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int            AW          = 12,
   parameter int            DW          = 8,
   parameter int            UNLOCK_BITS = 11,
   parameter logic [AW-1:0] ADDR_A1     = AW'('h555),
   parameter logic [AW-1:0] ADDR_A2     = AW'('h2AA)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   input  logic          accel,
   output logic          prog_start,
   output logic          chip_erase_start,
   output logic          sect_erase_start,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data,
   output logic          bypass_mode,
   output logic          read_mode
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("flash_cmd_decoder: DW must be at least 8");
      end
      if (AW < 11) begin : g_bad_aw
         $error("flash_cmd_decoder: AW must hold the unlock addresses");
      end
      if (UNLOCK_BITS < 1) begin : g_bad_ub
         $error("flash_cmd_decoder: UNLOCK_BITS must be positive");
      end
   endgenerate

   wr_class_t cls;
   launch_t   launch;

   flash_cmd_match #(
      .AW(AW), .DW(DW), .UNLOCK_BITS(UNLOCK_BITS),
      .ADDR_A1(ADDR_A1), .ADDR_A2(ADDR_A2)
   ) match_i (
      .addr (wr_addr),
      .data (wr_data),
      .cls  (cls)
   );

   flash_cmd_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .busy        (busy),
      .accel       (accel),
      .cls         (cls),
      .launch      (launch),
      .bypass_mode (bypass_mode),
      .read_mode   (read_mode)
   );

   flash_cmd_launch #(.AW(AW), .DW(DW)) launch_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .launch           (launch),
      .addr             (wr_addr),
      .data             (wr_data),
      .prog_start       (prog_start),
      .chip_erase_start (chip_erase_start),
      .sect_erase_start (sect_erase_start),
      .op_addr          (op_addr),
      .op_data          (op_data)
   );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic accel,
   input logic prog_start,
   input logic chip_erase_start,
   input logic sect_erase_start,
   input logic bypass_mode,
   input logic read_mode
);
   logic any_start;
   assign any_start = prog_start | chip_erase_start | sect_erase_start;

   assert_modes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bypass_mode && read_mode));

   assert_launch_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, chip_erase_start, sect_erase_start}));

   assert_launch_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      any_start |=> !any_start);

   assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !any_start);

   assert_accel_forces_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(accel)) |-> bypass_mode);

   assert_accel_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(accel, 2) && !$past(accel))
      |-> read_mode);
endmodule

bind flash_cmd_decoder flash_cmd_chk chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .busy             (busy),
   .accel            (accel),
   .prog_start       (prog_start),
   .chip_erase_start (chip_erase_start),
   .sect_erase_start (sect_erase_start),
   .bypass_mode      (bypass_mode),
   .read_mode        (read_mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 8;

   typedef struct {
      int             kind;
      logic [AW-1:0]  addr;
      logic [DW-1:0]  data;
      string          req;
   } exp_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic          accel = 1'b0;
   logic          prog_start, chip_erase_start, sect_erase_start;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic          bypass_mode, read_mode;

   int        n_cmp = 0;
   int        n_bad = 0;
   bit        done = 1'b0;
   exp_item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_decoder #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .accel(accel),
      .prog_start(prog_start), .chip_erase_start(chip_erase_start),
      .sect_erase_start(sect_erase_start), .op_addr(op_addr),
      .op_data(op_data), .bypass_mode(bypass_mode), .read_mode(read_mode)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_op(input int kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string req);
      exp_item_t it;
      it.kind = kind; it.addr = a; it.data = d; it.req = req;
      exp_q.push_back(it);
   endtask

   task automatic unlock();
      wr(12'h555, 8'hAA);
      wr(12'h2AA, 8'h55);
   endtask

   task automatic modes(input bit byp, input string req);
      check(bypass_mode == byp, {req, " bypass_mode"}, bypass_mode, byp);
      check(read_mode == !byp, {req, " read_mode"}, read_mode, !byp);
   endtask

   // monitor: pops the scoreboard whenever a launch appears
   always @(negedge clk) begin
      if (rst_n && (prog_start || chip_erase_start || sect_erase_start)) begin
         int act_kind;
         act_kind = prog_start ? 1 : (chip_erase_start ? 2 : 3);
         check($countones({prog_start, chip_erase_start, sect_erase_start}) == 1,
               "R12 one pulse", $countones({prog_start, chip_erase_start, sect_erase_start}), 1);
         if (exp_q.size() == 0) begin
            check(1'b0, "R7/R9/R10 unexpected launch", act_kind, 0);
         end else begin
            exp_item_t it;
            it = exp_q.pop_front();
            check(act_kind == it.kind, {it.req, " kind"}, act_kind, it.kind);
            check(op_addr == it.addr, {it.req, " addr"}, op_addr, it.addr);
            check(op_data == it.data, {it.req, " data"}, op_data, it.data);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(read_mode == 1'b1, "R1 read_mode", read_mode, 1);
      check(bypass_mode == 1'b0, "R1 bypass_mode", bypass_mode, 0);
      check(!(prog_start | chip_erase_start | sect_erase_start), "R1 pulses", 1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 standard program
      unlock(); wr(12'h555, 8'hA0);
      expect_op(1, 12'h123, 8'h5A, "R2");
      wr(12'h123, 8'h5A);
      modes(1'b0, "R2");

      // R3 chip erase then sector erase
      unlock(); wr(12'h555, 8'h80); unlock();
      expect_op(2, 12'h000, 8'h00, "R3 chip");
      wr(12'h555, 8'h10);
      unlock(); wr(12'h555, 8'h80); unlock();
      expect_op(3, 12'h400, 8'h00, "R3 sector");
      wr(12'h400, 8'h30);
      modes(1'b0, "R3");

      // R9 broken sequences launch nothing
      unlock(); wr(12'h555, 8'h12);
      wr(12'h555, 8'hA0); wr(12'h010, 8'h77);
      wr(12'h555, 8'hAA); wr(12'h555, 8'hF0);
      wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h011, 8'h66);
      modes(1'b0, "R9");

      // R4 bypass entry
      unlock(); wr(12'h555, 8'h20);
      modes(1'b1, "R4");

      // R5 repeated two-cycle program
      wr(12'h000, 8'hA0);
      expect_op(1, 12'h200, 8'h11, "R5 first");
      wr(12'h200, 8'h11);
      wr(12'h7FF, 8'hA0);
      expect_op(1, 12'h201, 8'h22, "R5 second");
      wr(12'h201, 8'h22);
      modes(1'b1, "R5");

      // R7 foreign writes ignored in bypass
      wr(12'h555, 8'hF0);
      unlock(); wr(12'h555, 8'h20);
      wr(12'h300, 8'h33);
      modes(1'b1, "R7");

      // R6 four-cycle erases
      wr(12'h000, 8'h80); unlock();
      expect_op(3, 12'h500, 8'h00, "R6 sector");
      wr(12'h500, 8'h30);
      wr(12'h000, 8'h80); unlock();
      expect_op(2, 12'h000, 8'h00, "R6 chip");
      wr(12'h555, 8'h10);
      modes(1'b1, "R6");

      // R8 exit: wrong second cycle stays, correct one leaves
      wr(12'h000, 8'h90); wr(12'h000, 8'h12);
      modes(1'b1, "R8 aborted exit");
      wr(12'h000, 8'h90); wr(12'h000, 8'h00);
      modes(1'b0, "R8 exit");

      // R10 busy holds the sequence
      wr(12'h555, 8'hAA);
      busy = 1'b1;
      wr(12'h2AA, 8'h55);
      wr(12'h555, 8'hA0);
      busy = 1'b0;
      wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
      expect_op(1, 12'h0AB, 8'hC3, "R10");
      wr(12'h0AB, 8'hC3);
      modes(1'b0, "R10");

      // R11 acceleration
      @(negedge clk); accel = 1'b1;
      @(negedge clk);
      modes(1'b1, "R11 forced");
      wr(12'h000, 8'hA0);
      expect_op(1, 12'h3C0, 8'h9E, "R11 program");
      wr(12'h3C0, 8'h9E);
      wr(12'h000, 8'h90); wr(12'h000, 8'h00);
      modes(1'b1, "R11 exit blocked");
      @(negedge clk); accel = 1'b0;
      @(negedge clk);
      modes(1'b0, "R11 released");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2-R11 pending launches", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule